// File: doc/BRIEF.md
# Receive Descriptor Writeback Engine

This block takes frames arriving one byte per cycle on a valid/ready stream and stores each one in host memory. Before it accepts the first byte of a frame it fetches three words of the current receive descriptor: the control word, the size word and the buffer address. It then packs the frame bytes little-endian into 32-bit words and writes them to the buffer. When the frame ends, it rewrites the descriptor control word with the completed length and hands the descriptor back to software. Finally it steps the current-descriptor pointer, either to the next 32-byte slot or back to the ring base.

A frame that is too short is dropped. A descriptor that the engine does not own makes the frame be discarded. Each outcome raises its own sticky status flags, which are cleared by writing ones to them. Four counters keep totals of stored bytes, stored frames, broadcast frames and multicast frames. Frames are taken only while the receive-start input is high. Loading a new ring base also moves the current-descriptor pointer to that base.

Top module: `rxwb_engine`

## Requirements
- R1: While `rx_start` is low and no frame is in progress, `in_ready` stays low and the memory port is idle, whatever `in_valid` does.
- R2: A frame of fewer than 12 bytes sets flags bit 0 (receive done) and bit 1 (normal summary) one cycle after its last byte is taken. This holds even when the descriptor is not owned. A short frame leaves the descriptor word, the pointer and the counters unchanged.
- R3: A frame of 12 bytes or more whose descriptor control word has bit 31 clear sets flags bit 2 (no buffer) and bit 3 (abnormal summary) one cycle after its last byte. Its descriptor word, the pointer and the counters stay unchanged.
- R4: A stored frame of N bytes rewrites the descriptor word at offset 0 with the value ((N + 4) << 16) | 0x300.
- R5: After a stored frame, the current-descriptor pointer returns to the ring base when bit 15 of the descriptor word at offset 4 is set. Otherwise it advances by 32.
- R6: Frame byte i goes to byte address buffer + i, where the buffer address is the descriptor word at offset 8. Packing is little-endian within each 32-bit word. A final partial word touches only its valid bytes.
- R7: A stored frame whose first six bytes are all 0xFF increments the broadcast counter. Otherwise, a stored frame whose first byte has bit 0 set increments the multicast counter. A frame never increments both.
- R8: Each stored frame increments the frame counter by one and adds N + 4 to the byte counter.
- R9: A stored frame sets flags bits 0 and 1 two cycles after its last byte is taken, and not earlier.
- R10: `in_ready` is low during the descriptor fetch and the writeback. A frame that starts from idle is ready exactly five cycles after `in_valid` is presented.
- R11: Each flag stays set until a cycle in which the matching `flag_clr` bit is high.
- R12: A pulse on `base_wr` loads the ring base and moves `cur_desc` to the same value on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_start | input | 1 | Receive enable, sampled when a frame starts |
| base_wr | input | 1 | Load pulse for the ring base |
| base_addr | input | AW | Ring base byte address |
| flag_clr | input | 4 | Write-one-to-clear mask for `flags` |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Stream byte accepted on this cycle's edge |
| mem_req | output | 1 | Memory access request, always granted |
| mem_wr | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| cur_desc | output | AW | Current-descriptor byte address |
| flags | output | 4 | Sticky flags: 0 done, 1 normal summary, 2 no buffer, 3 abnormal summary |
| cnt_bytes | output | CNT_W | Stored bytes, including 4 per frame |
| cnt_frames | output | CNT_W | Stored frames |
| cnt_bcast | output | CNT_W | Stored broadcast frames |
| cnt_mcast | output | CNT_W | Stored multicast frames |

## Verification
Take the edge that accepts the last byte as edge E. The flags for a short frame or an unowned descriptor are due at E+1. For a stored frame, the descriptor word, the pointer, the counters and the done flags all land at E+2, so at E+1 the done flags must still read zero. The bench samples on falling edges: once half a cycle after E+1 and once half a cycle after E+2. It also counts the falling edges between presenting a frame and seeing `in_ready`, expecting five, which pins down the three-read fetch.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_F0,
      ST_F1,
      ST_F2,
      ST_F3,
      ST_RX,
      ST_END,
      ST_WB
   } rxwb_state_t;

   // flag bit positions
   localparam int unsigned FLG_DONE = 0;
   localparam int unsigned FLG_NSUM = 1;
   localparam int unsigned FLG_NOBUF = 2;
   localparam int unsigned FLG_ASUM = 3;
   localparam int unsigned FLG_N = 4;

   // descriptor field positions the engine decodes
   localparam int unsigned OWN_BIT = 31;
   localparam int unsigned WRAP_BIT = 15;

   localparam logic [15:0] WB_STATUS_LO = 16'h0300;
   localparam int unsigned WORD_BYTES = 4;
   localparam logic [7:0] ALL_ONES_BYTE = 8'hFF;

endpackage

// File: rtl/rxwb_packer.sv
module rxwb_packer #(
   parameter int AW = 32,
   parameter int LEN_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             beat,
   input  logic [7:0]       byte_in,
   input  logic             last,
   input  logic             store_en,
   input  logic [AW-1:0]    buf_addr,
   output logic             wr_pend,
   output logic [AW-1:0]    wr_addr,
   output logic [31:0]      wr_data,
   output logic [3:0]       wr_be,
   output logic [LEN_W-1:0] byte_cnt
);
   import rxwb_pkg::*;

   localparam int LANES = WORD_BYTES;
   localparam int LANE_W = $clog2(LANES);

   logic [LEN_W-1:0]  cnt_q;
   logic [31:0]       acc_q;
   logic [31:0]       acc_n;
   logic [LANES-1:0]  be_n;
   logic [LANE_W-1:0] lane;
   logic              word_done;
   logic [LEN_W-1:0]  word_off;

   assign lane      = cnt_q[LANE_W-1:0];
   assign word_done = beat && ((lane == {LANE_W{1'b1}}) || last);
   assign word_off  = {cnt_q[LEN_W-1:LANE_W], {LANE_W{1'b0}}};
   assign byte_cnt  = cnt_q;

   // each lane either takes the new byte or keeps what it holds;
   // lanes below the current one are valid for this word
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign acc_n[g*8 +: 8] = (lane == LANE_W'(g)) ? byte_in : acc_q[g*8 +: 8];
      assign be_n[g]         = (LANE_W'(g) <= lane);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         acc_q   <= '0;
         wr_pend <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         wr_be   <= '0;
      end else if (clear) begin
         cnt_q   <= '0;
         wr_pend <= 1'b0;
      end else begin
         wr_pend <= word_done && store_en;
         if (beat) begin
            acc_q <= acc_n;
            cnt_q <= cnt_q + LEN_W'(1);
         end
         if (word_done) begin
            wr_data <= acc_n;
            wr_be   <= be_n;
            wr_addr <= buf_addr + AW'(word_off);
         end
      end
   end

endmodule

// File: rtl/rxwb_dest_class.sv
module rxwb_dest_class #(
   parameter int ADDR_BYTES = 6,
   parameter int IDX_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             beat,
   input  logic [7:0]       byte_in,
   input  logic [IDX_W-1:0] byte_idx,
   output logic             is_bcast,
   output logic             is_mcast
);
   import rxwb_pkg::*;

   logic ones_q;
   logic group_q;
   logic in_dst;

   assign in_dst   = byte_idx < IDX_W'(ADDR_BYTES);
   assign is_bcast = ones_q;
   assign is_mcast = group_q && !ones_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_q  <= 1'b0;
         group_q <= 1'b0;
      end else if (clear) begin
         ones_q  <= 1'b1;
         group_q <= 1'b0;
      end else if (beat && in_dst) begin
         ones_q <= ones_q && (byte_in == ALL_ONES_BYTE);
         if (byte_idx == '0) group_q <= byte_in[0];
      end
   end

endmodule

// File: rtl/rxwb_counters.sv
module rxwb_counters #(
   parameter int CNT_W = 32,
   parameter int ADD_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bump,
   input  logic [ADD_W-1:0] add_bytes,
   input  logic             is_bcast,
   input  logic             is_mcast,
   output logic [CNT_W-1:0] cnt_bytes,
   output logic [CNT_W-1:0] cnt_frames,
   output logic [CNT_W-1:0] cnt_bcast,
   output logic [CNT_W-1:0] cnt_mcast
);
   localparam int N_UNIT = 3;

   logic [N_UNIT-1:0] hit;
   logic [CNT_W-1:0]  bytes_q;

   assign hit = {is_mcast, is_bcast, 1'b1};

   for (genvar g = 0; g < N_UNIT; g++) begin : g_unit
      logic [CNT_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                q <= '0;
         else if (bump && hit[g])   q <= q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bytes_q <= '0;
      else if (bump) bytes_q <= bytes_q + CNT_W'(add_bytes);
   end

   assign cnt_bytes  = bytes_q;
   assign cnt_frames = g_unit[0].q;
   assign cnt_bcast  = g_unit[1].q;
   assign cnt_mcast  = g_unit[2].q;

endmodule

// File: rtl/rxwb_engine.sv
module rxwb_engine #(
   parameter int AW = 32,
   parameter int LEN_W = 14,
   parameter int CNT_W = 32,
   parameter int DESC_BYTES = 32,
   parameter int MIN_LEN = 12,
   parameter int CRC_LEN = 4,
   parameter int ADDR_BYTES = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rx_start,
   input  logic                    base_wr,
   input  logic [AW-1:0]           base_addr,
   input  logic [3:0]              flag_clr,
   input  logic                    in_valid,
   input  logic [7:0]              in_data,
   input  logic                    in_last,
   output logic                    in_ready,
   output logic                    mem_req,
   output logic                    mem_wr,
   output logic [AW-1:0]           mem_addr,
   output logic [3:0]              mem_be,
   output logic [31:0]             mem_wdata,
   input  logic [31:0]             mem_rdata,
   output logic [AW-1:0]           cur_desc,
   output logic [3:0]              flags,
   output logic [CNT_W-1:0]        cnt_bytes,
   output logic [CNT_W-1:0]        cnt_frames,
   output logic [CNT_W-1:0]        cnt_bcast,
   output logic [CNT_W-1:0]        cnt_mcast
);
   import rxwb_pkg::*;

   localparam int OFF_SIZE = 4;
   localparam int OFF_BUF  = 8;
   localparam int WB_LEN_W = 16;

   // elaboration-time parameter checks
   if (LEN_W > WB_LEN_W - 1) begin : g_bad_len
      $error("LEN_W must leave room for the CRC bytes in a 16-bit field");
   end
   if (AW > 32 || AW < LEN_W) begin : g_bad_aw
      $error("AW must lie between LEN_W and 32");
   end
   if (DESC_BYTES < OFF_BUF + 4 || (DESC_BYTES % 4) != 0) begin : g_bad_desc
      $error("DESC_BYTES must be a multiple of 4 holding three words");
   end
   if (MIN_LEN < ADDR_BYTES) begin : g_bad_min
      $error("MIN_LEN must cover the destination address");
   end

   rxwb_state_t state_q, state_n;

   logic             own_q;
   logic             wrap_q;
   logic [AW-1:0]    buf_q;
   logic [AW-1:0]    cur_q;
   logic [AW-1:0]    base_q;
   logic [FLG_N-1:0] flags_q;
   logic [FLG_N-1:0] flag_set;

   logic             fetch_req;
   logic [AW-1:0]    fetch_addr;
   logic             beat;
   logic             pk_pend;
   logic [AW-1:0]    pk_addr;
   logic [31:0]      pk_data;
   logic [3:0]       pk_be;
   logic [LEN_W-1:0] pk_cnt;
   logic             cls_bcast;
   logic             cls_mcast;
   logic             is_runt;
   logic             stored;
   logic             in_wb;
   logic [WB_LEN_W-1:0] wb_len;

   assign in_ready = (state_q == ST_RX);
   assign beat     = in_ready && in_valid;
   assign is_runt  = pk_cnt < LEN_W'(MIN_LEN);
   assign stored   = !is_runt && own_q;
   assign in_wb    = (state_q == ST_WB);
   assign wb_len   = WB_LEN_W'(pk_cnt) + WB_LEN_W'(CRC_LEN);

   // ---------------- control ----------------
   always_comb begin
      state_n    = state_q;
      fetch_req  = 1'b0;
      fetch_addr = cur_q;
      unique case (state_q)
         ST_IDLE: if (rx_start && in_valid) state_n = ST_F0;
         ST_F0: begin
            fetch_req = 1'b1;
            state_n   = ST_F1;
         end
         ST_F1: begin
            fetch_req  = 1'b1;
            fetch_addr = cur_q + AW'(OFF_SIZE);
            state_n    = ST_F2;
         end
         ST_F2: begin
            fetch_req  = 1'b1;
            fetch_addr = cur_q + AW'(OFF_BUF);
            state_n    = ST_F3;
         end
         ST_F3: state_n = ST_RX;
         ST_RX: if (in_valid && in_last) state_n = ST_END;
         ST_END: state_n = stored ? ST_WB : ST_IDLE;
         ST_WB: state_n = ST_IDLE;
         default: state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_n;
   end

   // descriptor capture: read data arrives one cycle after its request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q  <= 1'b0;
         wrap_q <= 1'b0;
         buf_q  <= '0;
      end else begin
         if (state_q == ST_F1) own_q  <= mem_rdata[OWN_BIT];
         if (state_q == ST_F2) wrap_q <= mem_rdata[WRAP_BIT];
         if (state_q == ST_F3) buf_q  <= mem_rdata[AW-1:0];
      end
   end

   // ring pointer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cur_q  <= '0;
      end else if (base_wr) begin
         base_q <= base_addr;
         cur_q  <= base_addr;
      end else if (in_wb) begin
         cur_q <= wrap_q ? base_q : cur_q + AW'(DESC_BYTES);
      end
   end
   assign cur_desc = cur_q;

   // sticky flags, set wins over clear
   always_comb begin
      flag_set = '0;
      if (state_q == ST_END) begin
         if (is_runt) begin
            flag_set[FLG_DONE] = 1'b1;
            flag_set[FLG_NSUM] = 1'b1;
         end else if (!own_q) begin
            flag_set[FLG_NOBUF] = 1'b1;
            flag_set[FLG_ASUM]  = 1'b1;
         end
      end
      if (in_wb) begin
         flag_set[FLG_DONE] = 1'b1;
         flag_set[FLG_NSUM] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~flag_clr) | flag_set;
   end
   assign flags = flags_q;

   // ---------------- memory port ----------------
   always_comb begin
      mem_req   = fetch_req || pk_pend || in_wb;
      mem_wr    = 1'b0;
      mem_addr  = fetch_addr;
      mem_be    = '0;
      mem_wdata = '0;
      if (in_wb) begin
         mem_wr    = 1'b1;
         mem_addr  = cur_q;
         mem_be    = 4'hF;
         mem_wdata = {wb_len, WB_STATUS_LO};
      end else if (pk_pend) begin
         mem_wr    = 1'b1;
         mem_addr  = pk_addr;
         mem_be    = pk_be;
         mem_wdata = pk_data;
      end
   end

   // ---------------- datapath units ----------------
   rxwb_packer #(
      .AW    (AW),
      .LEN_W (LEN_W)
   ) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (state_q == ST_F0),
      .beat     (beat),
      .byte_in  (in_data),
      .last     (in_last),
      .store_en (own_q),
      .buf_addr (buf_q),
      .wr_pend  (pk_pend),
      .wr_addr  (pk_addr),
      .wr_data  (pk_data),
      .wr_be    (pk_be),
      .byte_cnt (pk_cnt)
   );

   rxwb_dest_class #(
      .ADDR_BYTES (ADDR_BYTES),
      .IDX_W      (LEN_W)
   ) u_class (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (state_q == ST_F0),
      .beat     (beat),
      .byte_in  (in_data),
      .byte_idx (pk_cnt),
      .is_bcast (cls_bcast),
      .is_mcast (cls_mcast)
   );

   rxwb_counters #(
      .CNT_W (CNT_W),
      .ADD_W (WB_LEN_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .bump       (in_wb),
      .add_bytes  (wb_len),
      .is_bcast   (cls_bcast),
      .is_mcast   (cls_mcast),
      .cnt_bytes  (cnt_bytes),
      .cnt_frames (cnt_frames),
      .cnt_bcast  (cnt_bcast),
      .cnt_mcast  (cnt_mcast)
   );

endmodule

// File: rtl/rxwb_chk.sv
module rxwb_chk #(
   parameter int AW = 32,
   parameter int CNT_W = 32,
   parameter int DESC_BYTES = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 rx_start,
   input logic                 base_wr,
   input logic [3:0]           flag_clr,
   input logic                 in_ready,
   input logic                 mem_req,
   input logic                 mem_wr,
   input logic [AW-1:0]        mem_addr,
   input logic [3:0]           mem_be,
   input logic [31:0]          mem_wdata,
   input logic [AW-1:0]        cur_desc,
   input logic [AW-1:0]        ring_base,
   input logic [3:0]           flags,
   input logic [CNT_W-1:0]     cnt_frames,
   input logic [CNT_W-1:0]     cnt_bcast,
   input logic [CNT_W-1:0]     cnt_mcast,
   input rxwb_pkg::rxwb_state_t state
);
   import rxwb_pkg::*;

   // R1
   gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !rx_start) |-> (!in_ready && !mem_req));

   // R10
   ready_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !(mem_req && !mem_wr));

   // R10
   wb_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WB) |-> !in_ready);

   // R4
   wb_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WB) |-> (mem_req && mem_wr && mem_addr == cur_desc &&
                            mem_be == 4'hF && mem_wdata[15:0] == 16'h0300));

   // R5
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_WB && !$past(base_wr)) |->
      (cur_desc == ring_base || cur_desc == $past(cur_desc) + AW'(DESC_BYTES)));

   // R11
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));

   // R8
   frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_frames == $past(cnt_frames)) || (cnt_frames == $past(cnt_frames) + CNT_W'(1)));

   // R7
   class_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((cnt_bcast != $past(cnt_bcast)) && (cnt_mcast != $past(cnt_mcast))));

   // R9
   done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_frames != $past(cnt_frames)) |-> (flags[0] && flags[1]));

endmodule

bind rxwb_engine rxwb_chk #(
   .AW         (AW),
   .CNT_W      (CNT_W),
   .DESC_BYTES (DESC_BYTES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_start   (rx_start),
   .base_wr    (base_wr),
   .flag_clr   (flag_clr),
   .in_ready   (in_ready),
   .mem_req    (mem_req),
   .mem_wr     (mem_wr),
   .mem_addr   (mem_addr),
   .mem_be     (mem_be),
   .mem_wdata  (mem_wdata),
   .cur_desc   (cur_desc),
   .ring_base  (base_q),
   .flags      (flags),
   .cnt_frames (cnt_frames),
   .cnt_bcast  (cnt_bcast),
   .cnt_mcast  (cnt_mcast),
   .state      (state_q)
);

// File: tb/tb_rxwb_engine.sv
module tb_rxwb_engine;

   localparam int AW = 32;
   localparam int CNT_W = 32;
   localparam logic [31:0] RING = 32'h40;
   localparam logic [31:0] BUF = 32'h200;
   localparam int BUF_W0 = 128;

   // {len[7:0], kind[1:0], own, wrap}; kind 0 unicast, 1 multicast,
   // 2 broadcast, 3 all-ones except last address byte
   localparam logic [11:0] VEC [0:8] = '{
      {8'd64, 2'd0, 1'b1, 1'b0},
      {8'd13, 2'd1, 1'b1, 1'b0},
      {8'd30, 2'd2, 1'b1, 1'b1},
      {8'd11, 2'd0, 1'b1, 1'b0},
      {8'd40, 2'd1, 1'b0, 1'b0},
      {8'd12, 2'd2, 1'b1, 1'b0},
      {8'd6,  2'd2, 1'b0, 1'b0},
      {8'd20, 2'd3, 1'b1, 1'b0},
      {8'd47, 2'd0, 1'b1, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_start = 1'b0;
   logic base_wr = 1'b0;
   logic [AW-1:0] base_addr = '0;
   logic [3:0] flag_clr = '0;
   logic in_valid = 1'b0;
   logic [7:0] in_data = '0;
   logic in_last = 1'b0;
   logic in_ready;
   logic mem_req, mem_wr;
   logic [AW-1:0] mem_addr;
   logic [3:0] mem_be;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic [AW-1:0] cur_desc;
   logic [3:0] flags;
   logic [CNT_W-1:0] cnt_bytes, cnt_frames, cnt_bcast, cnt_mcast;

   logic [31:0] mem [0:255];
   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;   // 20 time units per cycle: 50 MHz at 1 ns

   rxwb_engine dut (
      .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .base_wr(base_wr),
      .base_addr(base_addr), .flag_clr(flag_clr), .in_valid(in_valid),
      .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
      .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .cur_desc(cur_desc), .flags(flags), .cnt_bytes(cnt_bytes),
      .cnt_frames(cnt_frames), .cnt_bcast(cnt_bcast), .cnt_mcast(cnt_mcast)
   );

   // memory model: reads return data on the following cycle
   always @(posedge clk) begin
      if (mem_req && mem_wr) begin
         for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[9:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end
      if (mem_req && !mem_wr) mem_rdata <= mem[mem_addr[9:2]];
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] fbyte(input int i, input int len, input int kind);
      if (i < 6) begin
         case (kind)
            0: return (i == 0) ? 8'h02 : 8'(8'h10 + i);
            1: return (i == 0) ? 8'h01 : 8'(8'h20 + i);
            2: return 8'hFF;
            default: return (i == 5) ? 8'hFE : 8'hFF;
         endcase
      end
      return 8'(i * 13 + len);
   endfunction

   // called just after a falling edge; returns just after the edge that took the last byte
   task automatic send_frame(input int len, input int kind, output int waits);
      waits = 0;
      for (int i = 0; i < len; i++) begin
         in_valid = 1'b1;
         in_data  = fbyte(i, len, kind);
         in_last  = (i == len - 1);
         while (!in_ready) begin
            @(negedge clk);
            if (i == 0) waits++;
         end
         @(negedge clk);
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] exp_cur;
      logic [31:0] e_bytes, e_frames, e_bc, e_mc;
      logic [31:0] old_w0;
      int waits;

      for (int k = 0; k < 256; k++) mem[k] = 32'h0;
      e_bytes = 0; e_frames = 0; e_bc = 0; e_mc = 0;

      repeat (3) @(negedge clk);
      // reset state
      chk("R1 reset in_ready", in_ready, 0);
      chk("R1 reset mem_req", mem_req, 0);
      chk("R11 reset flags", flags, 0);
      chk("R8 reset frames", cnt_frames, 0);
      chk("R12 reset cur_desc", cur_desc, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R12: base load moves the pointer
      base_addr = RING; base_wr = 1'b1;
      @(negedge clk);
      base_wr = 1'b0;
      chk("R12 cur_desc after base load", cur_desc, RING);
      exp_cur = RING;

      // R1: gate closed, a frame waits
      in_valid = 1'b1; in_data = 8'h55;
      for (int c = 0; c < 8; c++) begin
         @(negedge clk);
         chk("R1 in_ready gated", in_ready, 0);
         chk("R1 memory idle gated", mem_req, 0);
      end
      in_valid = 1'b0;
      chk("R1 pointer unchanged gated", cur_desc, RING);
      rx_start = 1'b1;

      for (int v = 0; v < 9; v++) begin
         int len, kind;
         bit own, wrap, runt, ok;
         len  = int'(VEC[v][11:4]);
         kind = int'(VEC[v][3:2]);
         own  = VEC[v][1];
         wrap = VEC[v][0];
         runt = (len < 12);
         ok   = !runt && own;

         mem[exp_cur[9:2]]     = own ? 32'h8000_0000 : 32'h0;
         mem[exp_cur[9:2] + 1] = (wrap ? 32'h8000 : 32'h0) | 32'h0800;
         mem[exp_cur[9:2] + 2] = BUF;
         for (int k = 0; k < 64; k++) mem[BUF_W0 + k] = 32'hA5A5A5A5;
         old_w0 = mem[exp_cur[9:2]];
         flag_clr = 4'hF;
         @(negedge clk);
         flag_clr = 4'h0;

         send_frame(len, kind, waits);
         chk("R10 fetch holds ready low five cycles", waits, 5);

         @(negedge clk);   // one edge after the last byte
         if (runt)      chk("R2 runt flags", flags, 4'b0011);
         else if (!own) chk("R3 unowned flags", flags, 4'b1100);
         else           chk("R9 done flags not early", flags, 4'b0000);

         @(negedge clk);   // two edges after the last byte
         if (ok) begin
            chk("R9 done flags", flags, 4'b0011);
            chk("R4 writeback word", mem[exp_cur[9:2]], ((len + 4) << 16) | 32'h300);
            exp_cur = wrap ? RING : exp_cur + 32;
            chk("R5 pointer step", cur_desc, exp_cur);
            for (int i = 0; i < len; i++)
               chk("R6 buffer byte", mem[BUF_W0 + i/4][(i%4)*8 +: 8], fbyte(i, len, kind));
            if ((len % 4) != 0)
               chk("R6 byte beyond frame untouched", mem[BUF_W0 + len/4][(len%4)*8 +: 8], 8'hA5);
            e_bytes  += len + 4;
            e_frames += 1;
            if (kind == 2) e_bc += 1;
            else if (kind == 1 || kind == 3) e_mc += 1;
         end else begin
            if (runt) chk("R2 runt descriptor unchanged", mem[exp_cur[9:2]], old_w0);
            else      chk("R3 unowned descriptor unchanged", mem[exp_cur[9:2]], old_w0);
            chk("R2 R3 pointer unchanged", cur_desc, exp_cur);
         end
         chk("R8 byte counter", cnt_bytes, e_bytes);
         chk("R8 frame counter", cnt_frames, e_frames);
         chk("R7 broadcast counter", cnt_bcast, e_bc);
         chk("R7 multicast counter", cnt_mcast, e_mc);
      end

      // R11: clear one flag, the other stays
      chk("R11 flags before clear", flags, 4'b0011);
      flag_clr = 4'b0001;
      @(negedge clk);
      flag_clr = 4'b0000;
      chk("R11 partial clear", flags, 4'b0010);
      @(negedge clk);
      chk("R11 flag holds", flags, 4'b0010);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule